// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block holds the control register group of a four-channel DMA engine. A host writes and reads it through a single byte-wide control port. Indices 8 to 15 carry the command, software request, single-channel mask, channel mode, flip-flop clear, master clear, mask clear and whole-mask load operations. Indices below 8 belong to the neighbouring address/count block and are ignored here. The unit keeps the command byte, the four-bit mask, one mode byte per channel and an eight-bit status byte. The upper nibble of status holds a request bit per channel. The lower nibble holds a terminal-count bit per channel.

Each channel's request bit can be set by software through the request register. Peripheral hold and release inputs and a terminal-count input also act on the status byte every cycle. From the mask and the request bits the unit forms a per-channel service-request vector. It then picks the lowest-numbered requester as a one-hot grant with a valid flag. The byte-pointer flip-flop lives in the address/count block, so this unit sends it a one-cycle clear pulse. All control pins are plain level signals with no handshake. A write or read takes effect on the clock edge where the strobe is high. Read data is combinational and valid while the read strobe is high, before that edge.

Top module: `chan_ctl_unit`

## Requirements
- R1: After power-on reset the status byte is 0x00, the mask is 0x0F, the command byte is 0x00, every mode byte is 0x00, no service request or grant is raised and the clear pulse is low.
- R2: A write at index 8 loads the command byte only when the data is 0x00 or 0x04. Any other value leaves the command byte unchanged.
- R3: A write at index 9 uses data[1:0] as the channel. It sets status bit (channel+4) when data[2] is 1 and clears it when data[2] is 0. In both cases it clears status bit (channel).
- R4: A write at index 10 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0.
- R5: A write at index 11 stores the whole data byte as the mode of channel data[1:0]. The mode of channel n appears on mode_flat[8n+7:8n].
- R6: A write at index 12 or 13 raises ff_clr for exactly the one cycle after the write edge. No other operation raises it.
- R7: A write at index 13 clears status and command and sets the mask to 0x0F. It leaves the mode bytes unchanged.
- R8: A write at index 14 clears the whole mask. A write at index 15 loads the mask from data[3:0].
- R9: A read at index 8 returns the status byte and clears status bits [3:0] at that edge. A read at index 15 returns {4'b0, mask}. Every other index reads 0x00. Writes at indices 0 to 7 change nothing.
- R10: hw_hold[n] sets status bit (n+4) and hw_release[n] clears it. Release wins over hold on the same bit. Both win over a register write in the same cycle.
- R11: tc_hit[n] sets status bit n. It wins over a status-read clear or a request-register clear in the same cycle.
- R12: svc_req[n] is 1 exactly when mask bit n is 0 and status bit (n+4) is 1. grant is one-hot on the lowest-numbered requesting channel, and grant_valid is 1 whenever any channel requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Control-port read strobe |
| ctl_idx | input | 4 | Register index, 8 to 15 decoded |
| ctl_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Read data, valid while ctl_rd is high |
| hw_hold | input | 4 | Per-channel peripheral request set |
| hw_release | input | 4 | Per-channel peripheral request clear |
| tc_hit | input | 4 | Per-channel terminal-count set |
| cmd_word | output | 8 | Current command byte |
| mode_flat | output | 32 | Four mode bytes, channel 0 in the low byte |
| ff_clr | output | 1 | One-cycle clear to the byte-pointer flip-flop |
| svc_req | output | 4 | Per-channel service request |
| grant | output | 4 | One-hot grant to the lowest requester |
| grant_valid | output | 1 | Any channel granted |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions on one status bit. These are a terminal count that lands on the edge of the status read that would clear it, and a release that meets a hold or a software request on the same channel. The bench reaches them with one cycle task that drives the control strobe, the hold and release vectors and the terminal-count vector together on the same edge. It then reads status back through index 8 on the following cycles and checks both the returned value and the cleared state.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
  localparam int NCH = 4;
  localparam int DW  = 8;
  localparam int IW  = 4;
  localparam int CHW = $clog2(NCH);
  localparam int NOPS = 8;
  localparam logic [DW-1:0] CMD_ALLOWED = 8'h04;

  typedef enum logic [2:0] {
    OP_CMD    = 3'd0,
    OP_REQ    = 3'd1,
    OP_SMASK  = 3'd2,
    OP_MODE   = 3'd3,
    OP_CLRFF  = 3'd4,
    OP_MCLR   = 3'd5,
    OP_CLRMSK = 3'd6,
    OP_LDMSK  = 3'd7
  } ctl_op_e;
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import chan_ctl_pkg::*;
(
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [IW-1:0] idx,
  output logic [NOPS-1:0] wr_stb,
  output logic [NOPS-1:0] rd_stb
);
  logic in_range;
  assign in_range = idx[IW-1];

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    assign wr_stb[g] = wr_en && in_range && (idx[IW-2:0] == 3'(g));
    assign rd_stb[g] = rd_en && in_range && (idx[IW-2:0] == 3'(g));
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import chan_ctl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           master_clr,
  input  logic           req_we,
  input  logic [CHW-1:0] req_ch,
  input  logic           req_set,
  input  logic           rd_clr,
  input  logic [NCH-1:0] hold,
  input  logic [NCH-1:0] rel,
  input  logic [NCH-1:0] tc_set,
  output logic [2*NCH-1:0] status_q
);
  logic [NCH-1:0] req_nxt, tc_nxt;

  always_comb begin
    req_nxt = status_q[2*NCH-1:NCH];
    tc_nxt  = status_q[NCH-1:0];
    if (rd_clr) tc_nxt = '0;
    if (req_we) begin
      req_nxt[req_ch] = req_set;
      tc_nxt[req_ch]  = 1'b0;
    end
    if (master_clr) begin
      req_nxt = '0;
      tc_nxt  = '0;
    end
    req_nxt = (req_nxt | hold) & ~rel;
    tc_nxt  = tc_nxt | tc_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= {req_nxt, tc_nxt};
  end
endmodule

// File: rtl/mask_mode_regs.sv
module mask_mode_regs
  import chan_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOPS-1:0] wr_stb,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   cmd_q,
  output logic [NCH-1:0]  mask_q,
  output logic [NCH*DW-1:0] mode_q,
  output logic            ff_clr_q
);
  logic [CHW-1:0] sel;
  logic           cmd_ok;
  assign sel    = wdata[CHW-1:0];
  assign cmd_ok = (wdata & ~CMD_ALLOWED) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      mask_q   <= '1;
      ff_clr_q <= 1'b0;
    end else begin
      ff_clr_q <= wr_stb[OP_CLRFF] | wr_stb[OP_MCLR];
      if (wr_stb[OP_CMD] && cmd_ok) cmd_q <= wdata;
      if (wr_stb[OP_MCLR]) begin
        cmd_q  <= '0;
        mask_q <= '1;
      end else if (wr_stb[OP_CLRMSK]) begin
        mask_q <= '0;
      end else if (wr_stb[OP_LDMSK]) begin
        mask_q <= wdata[NCH-1:0];
      end else if (wr_stb[OP_SMASK]) begin
        mask_q[sel] <= wdata[2];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[c*DW +: DW] <= '0;
      else if (wr_stb[OP_MODE] && sel == CHW'(c)) mode_q[c*DW +: DW] <= wdata;
    end
  end
endmodule

// File: rtl/grant_pick.sv
module grant_pick
  import chan_ctl_pkg::*;
(
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic           any
);
  logic [NCH:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < NCH; g++) begin : g_chain
    assign gnt[g]    = req[g] & ~seen[g];
    assign seen[g+1] = seen[g] | req[g];
  end
  assign any = seen[NCH];
endmodule

// File: rtl/chan_ctl_unit.sv
module chan_ctl_unit
  import chan_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic [IW-1:0]     ctl_idx,
  input  logic [DW-1:0]     ctl_wdata,
  output logic [DW-1:0]     ctl_rdata,
  input  logic [NCH-1:0]    hw_hold,
  input  logic [NCH-1:0]    hw_release,
  input  logic [NCH-1:0]    tc_hit,
  output logic [DW-1:0]     cmd_word,
  output logic [NCH*DW-1:0] mode_flat,
  output logic              ff_clr,
  output logic [NCH-1:0]    svc_req,
  output logic [NCH-1:0]    grant,
  output logic              grant_valid
);
  logic [NOPS-1:0]  wr_stb, rd_stb;
  logic [2*NCH-1:0] status_q;
  logic [NCH-1:0]   mask_q;

  ctl_decode u_dec (
    .wr_en(ctl_wr), .rd_en(ctl_rd), .idx(ctl_idx),
    .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  status_reg u_stat (
    .clk(clk), .rst_n(rst_n),
    .master_clr(wr_stb[OP_MCLR]),
    .req_we(wr_stb[OP_REQ]),
    .req_ch(ctl_wdata[CHW-1:0]),
    .req_set(ctl_wdata[2]),
    .rd_clr(rd_stb[OP_CMD]),
    .hold(hw_hold), .rel(hw_release), .tc_set(tc_hit),
    .status_q(status_q)
  );

  mask_mode_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_stb), .wdata(ctl_wdata),
    .cmd_q(cmd_word), .mask_q(mask_q), .mode_q(mode_flat),
    .ff_clr_q(ff_clr)
  );

  assign svc_req = ~mask_q & status_q[2*NCH-1:NCH];

  grant_pick u_pick (.req(svc_req), .gnt(grant), .any(grant_valid));

  always_comb begin
    ctl_rdata = '0;
    if (rd_stb[OP_CMD])        ctl_rdata = status_q;
    else if (rd_stb[OP_LDMSK]) ctl_rdata = DW'(mask_q);
  end
endmodule

// File: rtl/chan_ctl_chk.sv
module chan_ctl_chk
  import chan_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_wr,
  input logic              ctl_rd,
  input logic [IW-1:0]     ctl_idx,
  input logic [DW-1:0]     ctl_wdata,
  input logic [NCH-1:0]    hw_release,
  input logic [NCH-1:0]    tc_hit,
  input logic [2*NCH-1:0]  status_q,
  input logic [DW-1:0]     cmd_word,
  input logic              ff_clr,
  input logic [NCH-1:0]    svc_req,
  input logic [NCH-1:0]    grant,
  input logic              grant_valid
);
  // R12
  grant_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~svc_req) == '0) && (grant_valid == (svc_req != '0)));

  // R2
  cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_idx == 4'h8 && (ctl_wdata & ~CMD_ALLOWED) != '0) |=> $stable(cmd_word));

  // R6
  ffclr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (ctl_idx == 4'hC || ctl_idx == 4'hD)) |=> ff_clr);

  // R6
  ffclr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_wr && (ctl_idx == 4'hC || ctl_idx == 4'hD)) |=> !ff_clr);

  // R9
  rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && ctl_idx == 4'h8 && tc_hit == '0) |=> status_q[NCH-1:0] == '0);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_release != '0) |=> (status_q[2*NCH-1:NCH] & $past(hw_release)) == '0);
endmodule

bind chan_ctl_unit chan_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .ctl_idx(ctl_idx), .ctl_wdata(ctl_wdata), .hw_release(hw_release),
  .tc_hit(tc_hit), .status_q(status_q), .cmd_word(cmd_word),
  .ff_clr(ff_clr), .svc_req(svc_req), .grant(grant), .grant_valid(grant_valid)
);

// File: tb/tb_chan_ctl_unit.sv
`timescale 1ns/1ps
module tb_chan_ctl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0, ctl_rd = 1'b0;
  logic [3:0]  ctl_idx = '0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic [3:0]  hw_hold = '0, hw_release = '0, tc_hit = '0;
  logic [7:0]  cmd_word;
  logic [31:0] mode_flat;
  logic        ff_clr;
  logic [3:0]  svc_req, grant;
  logic        grant_valid;

  int n_chk = 0, n_bad = 0;
  logic [7:0] last_rd;
  logic [31:0] modes_keep;

  always #2 clk = ~clk;

  chan_ctl_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at negedge, released at the next negedge
  task automatic cyc(input logic w, input logic r, input logic [3:0] ix, input logic [7:0] d,
                     input logic [3:0] h, input logic [3:0] rl, input logic [3:0] tc);
    ctl_wr = w; ctl_rd = r; ctl_idx = ix; ctl_wdata = d;
    hw_hold = h; hw_release = rl; tc_hit = tc;
    #1 last_rd = ctl_rdata;
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; ctl_rd = 0; ctl_idx = 0; ctl_wdata = 0;
    hw_hold = 0; hw_release = 0; tc_hit = 0;
  endtask

  task automatic wr(input logic [3:0] ix, input logic [7:0] d);
    cyc(1, 0, ix, d, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic rd(input logic [3:0] ix);
    cyc(0, 1, ix, 8'h00, 4'h0, 4'h0, 4'h0);
  endtask

  // {is_read, idx, data, expected read data, expected svc_req}
  typedef struct packed {
    logic       is_rd;
    logic [3:0] idx;
    logic [7:0] data;
    logic [7:0] exp_rd;
    logic [3:0] exp_svc;
  } vec_t;

  localparam vec_t VECS [19] = '{
    '{1'b0, 4'h9, 8'h05, 8'h00, 4'h0},  // R3 request ch1, masked
    '{1'b1, 4'hF, 8'h00, 8'h0F, 4'h0},  // R9 mask read
    '{1'b0, 4'hA, 8'h01, 8'h00, 4'h2},  // R4 unmask ch1
    '{1'b1, 4'h8, 8'h00, 8'h20, 4'h2},  // R9 status read
    '{1'b0, 4'h9, 8'h06, 8'h00, 4'h2},  // R3 request ch2
    '{1'b0, 4'hE, 8'h00, 8'h00, 4'h6},  // R8 clear all
    '{1'b0, 4'hF, 8'h09, 8'h00, 4'h6},  // R8 load mask
    '{1'b1, 4'hF, 8'h00, 8'h09, 4'h6},  // R8 mask readback
    '{1'b0, 4'hA, 8'h05, 8'h00, 4'h4},  // R4 mask ch1
    '{1'b0, 4'h9, 8'h02, 8'h00, 4'h0},  // R3 clear ch2 request
    '{1'b1, 4'h8, 8'h00, 8'h20, 4'h0},  // R9 status
    '{1'b1, 4'h3, 8'h00, 8'h00, 4'h0},  // R9 low index reads 0
    '{1'b1, 4'hA, 8'h00, 8'h00, 4'h0},  // R9 other index reads 0
    '{1'b0, 4'h1, 8'hFF, 8'h00, 4'h0},  // R9 low index write ignored
    '{1'b1, 4'hF, 8'h00, 8'h0B, 4'h0},  // R9 mask untouched
    '{1'b1, 4'h8, 8'h00, 8'h20, 4'h0},  // R9 status untouched
    '{1'b0, 4'hD, 8'h00, 8'h00, 4'h0},  // R7 master clear
    '{1'b1, 4'h8, 8'h00, 8'h00, 4'h0},  // R7 status cleared
    '{1'b1, 4'hF, 8'h00, 8'h0F, 4'h0}   // R7 mask all set
  };

  initial begin
    #40000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cmd", cmd_word, 8'h00);
    chk("R1 mode", mode_flat, 32'h0);
    chk("R1 svc", {ff_clr, grant_valid, grant, svc_req}, 10'h0);
    rd(4'h8); chk("R1 status", last_rd, 8'h00);
    rd(4'hF); chk("R1 mask", last_rd, 8'h0F);

    foreach (VECS[i]) begin
      if (VECS[i].is_rd) begin
        rd(VECS[i].idx);
        chk("R9 vector read", last_rd, VECS[i].exp_rd);
      end else begin
        wr(VECS[i].idx, VECS[i].data);
      end
      chk("R12 vector svc", svc_req, VECS[i].exp_svc);
    end

    // R2 command filter
    wr(4'h8, 8'h04); chk("R2 accept 04", cmd_word, 8'h04);
    wr(4'h8, 8'h01); chk("R2 reject 01", cmd_word, 8'h04);
    wr(4'h8, 8'h00); chk("R2 accept 00", cmd_word, 8'h00);
    wr(4'h8, 8'h80); chk("R2 reject 80", cmd_word, 8'h00);
    wr(4'h8, 8'h04);

    // R5 mode bytes
    wr(4'hB, 8'h56); chk("R5 ch2 mode", mode_flat, 32'h0056_0000);
    wr(4'hB, 8'hC7); chk("R5 ch3 mode", mode_flat, 32'hC756_0000);

    // R6 flip-flop clear pulse
    wr(4'hC, 8'h00); chk("R6 pulse", ff_clr, 1'b1);
    @(negedge clk);  chk("R6 one cycle", ff_clr, 1'b0);
    wr(4'hA, 8'h04); chk("R6 quiet", ff_clr, 1'b0);

    // R10 hold and release
    wr(4'hE, 8'h00);
    cyc(0, 0, 4'h0, 8'h00, 4'b1000, 4'b0000, 4'h0);
    chk("R10 hold", svc_req, 4'b1000);
    chk("R12 grant ch3", {grant_valid, grant}, 5'b11000);
    cyc(0, 0, 4'h0, 8'h00, 4'b0100, 4'b1000, 4'h0);
    chk("R10 hold+release", svc_req, 4'b0100);
    cyc(0, 0, 4'h0, 8'h00, 4'b0001, 4'b0001, 4'h0);
    chk("R10 release wins", svc_req, 4'b0100);
    cyc(0, 0, 4'h0, 8'h00, 4'b0000, 4'b0100, 4'h0);
    chk("R10 release", svc_req, 4'b0000);
    cyc(1, 0, 4'h9, 8'h04, 4'b0000, 4'b0001, 4'h0);
    chk("R10 hw beats sw", svc_req, 4'b0000);
    rd(4'h8); chk("R10 status", last_rd, 8'h00);

    // R11 terminal count collisions
    cyc(0, 0, 4'h0, 8'h00, 4'h0, 4'h0, 4'b0010);
    rd(4'h8); chk("R11 tc set", last_rd, 8'h02);
    rd(4'h8); chk("R11 read cleared", last_rd, 8'h00);
    cyc(0, 1, 4'h8, 8'h00, 4'h0, 4'h0, 4'b0001);
    chk("R11 read old", last_rd, 8'h00);
    rd(4'h8); chk("R11 tc beats read clear", last_rd, 8'h01);
    cyc(1, 0, 4'h9, 8'h00, 4'h0, 4'h0, 4'b0001);
    rd(4'h8); chk("R11 tc beats req clear", last_rd, 8'h01);

    // R12 priority
    cyc(0, 0, 4'h0, 8'h00, 4'b1111, 4'h0, 4'h0);
    chk("R12 all req", svc_req, 4'hF);
    chk("R12 grant ch0", {grant_valid, grant}, 5'b10001);
    wr(4'hA, 8'h04); chk("R12 grant ch1", grant, 4'b0010);
    wr(4'hF, 8'h0E); chk("R12 grant ch0 again", grant, 4'b0001);
    wr(4'hF, 8'h0F); chk("R12 none", {grant_valid, grant}, 5'b00000);

    // R7 master clear keeps modes
    modes_keep = mode_flat;
    cyc(0, 0, 4'h0, 8'h00, 4'h0, 4'h0, 4'b1000);
    wr(4'hD, 8'h00);
    chk("R7 ff pulse", ff_clr, 1'b1);
    chk("R7 cmd", cmd_word, 8'h00);
    chk("R7 modes kept", mode_flat, modes_keep);
    rd(4'h8); chk("R7 status", last_rd, 8'h00);
    rd(4'hF); chk("R7 mask", last_rd, 8'h0F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule